// File: doc/BRIEF.md
# I2C Slave Transmitter with Host Flags

This block is the target side of an I2C link. It watches the bus for a START, takes in the first byte after it and compares its upper seven bits with a programmable own address. When the address matches, it answers the ninth clock with a host-chosen level. If the direction bit asks for a read, it then turns itself into a transmitter with no host action. The host feeds bytes through a one-byte transmit holding register. Three flags pace the host: transmit mode, transmit holding register empty, and transmission ended.

While the holding register is empty at the start of a byte, the slave holds SCL low. The same hold applies after a byte whose acknowledge clock ends with nothing queued. To close a read, the host clears the transmit-mode flag and then reads the receive register as a dummy access, and only that releases SCL. A NACK from the master stops shifting at once and frees both lines so the master can send STOP. Both bus lines pass through a two-flop synchronizer and a glitch filter. The filter length comes from a 4-bit select field. Both lines are open drain, modelled as a sampled input plus an output enable that pulls the line low.

Top module: `i2c_slave_tx`

## Requirements
- R1: A START (SDA falling while SCL is high) opens an address frame and a STOP (SDA rising while SCL is high) returns the slave to idle; if bits 7..1 of the first byte differ from `own_addr` the slave leaves SDA released on the 9th clock (the master reads 1) and `trs` stays unchanged.
- R2: On an address match the slave drives the 9th clock's SDA to the level of `ack_sel`: 0 pulls SDA low (ACK), 1 leaves it released (reads 1).
- R3: A matching address with bit 0 (R/W) equal to 1 sets `trs` and `tdre` to 1; with R/W equal to 0 it clears `trs`, leaves `tdre` unchanged and places the whole address byte on `rxd`.
- R4: Transmit bytes appear on SDA most significant bit first, and `sda_oe` changes only while SCL is low.
- R5: A `wr_txd` pulse makes `tdre` 0 on the following cycle; when that byte moves into the shift register at the start of its byte time, `tdre` returns to 1.
- R6: If `tdre` is 1 when a byte must start, `scl_oe` stays 1 (SCL held low) until the host writes a byte, and falls within three cycles of the write.
- R7: When the master ACKs (SDA low on the 9th clock) and `tdre` is 1 at the end of that clock, `tend` becomes 1 and SCL is held low.
- R8: A held-end SCL is released only by a `rd_rxd` pulse taken while `trs` is already 0; `rd_rxd` with `trs` at 1 and `clr_trs` alone leave SCL held; the release clears `tdre`.
- R9: A NACK (SDA high on the 9th clock) sets `tend`, and both `scl_oe` and `sda_oe` are 0 afterwards, so further master clocks read 1.
- R10: A `clr_tend` pulse returns `tend` to 0.
- R11: With `en` at 0 the slave releases both lines, holds `trs`, `tdre` and `tend` at 0, and ignores its address.
- R12: A change on SDA or SCL lasting fewer than `clk_sel`+1 system clocks is filtered out; a 2-cycle SDA dip while SCL is high with `clk_sel`=3 is not seen as START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; 0 idles the slave and clears its flags |
| clk_sel | input | 4 | Glitch filter length: a line change must persist clk_sel+1 clocks |
| ack_sel | input | 1 | SDA level returned on the address acknowledge clock |
| own_addr | input | 7 | Own 7-bit slave address |
| wr_txd | input | 1 | Write strobe for the transmit holding register |
| txd | input | 8 | Byte written with wr_txd |
| rd_rxd | input | 1 | Read strobe of the receive register (dummy read ends a transfer) |
| rxd | output | 8 | Last address byte taken in |
| clr_trs | input | 1 | Clears the transmit-mode flag |
| clr_tend | input | 1 | Clears the transmission-end flag |
| trs | output | 1 | Transmit-mode flag |
| tdre | output | 1 | Transmit holding register empty flag |
| tend | output | 1 | Transmission-end flag |
| scl_i | input | 1 | Sampled SCL bus level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_i | input | 1 | Sampled SDA bus level |
| sda_oe | output | 1 | Pulls SDA low when 1 |

## Verification
A bit counter off by one shows within the same byte: the master reads a shifted data value and the acknowledge clock falls on the wrong bit, so the ACK or NACK lands in the data. A wrong state after the acknowledge clock shows in the next few system clocks at the bus. Either SCL stays free when the bench expects it held, or SCL stays held after the trs-clear-then-read sequence, or `tend` or `tdre` disagree with the flag model. Filter or edge-detect faults show as a missing or spurious acknowledge on the very next address frame.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_TXHOLD,
        ST_TXBITS,
        ST_TXACK
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic trs;
        logic tdre;
        logic tend;
    } slv_flags_t;

    function automatic bus_evt_t decode_bus(input logic scl, input logic scl_d,
                                            input logic sda, input logic sda_d);
        bus_evt_t e;
        e.rise  = scl & ~scl_d;
        e.fall  = ~scl & scl_d;
        e.start = scl & scl_d & sda_d & ~sda;
        e.stop  = scl & scl_d & ~sda_d & sda;
        e.sda   = sda;
        return e;
    endfunction

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] thr,
    input  logic             line_i,
    output logic             line_o
);
    localparam int SMSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [SEL_W-1:0]       run_q;
    logic                   filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            run_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (sync_q[SMSB] == filt_q) begin
                run_q <= '0;
            end else if (run_q == thr) begin
                filt_q <= sync_q[SMSB];
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign line_o = filt_q;
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events
    import i2cs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    always_comb evt = decode_bus(scl_f, scl_d, sda_f, sda_d);
endmodule

// File: rtl/i2cs_slv_engine.sv
module i2cs_slv_engine
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ack_sel,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              wr_txd,
    input  logic [DATA_W-1:0] txd,
    input  logic              rd_rxd,
    input  logic              clr_trs,
    input  logic              clr_tend,
    input  bus_evt_t          evt,
    output logic [DATA_W-1:0] rxd,
    output slv_flags_t        flags,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    slv_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shr_q, txbuf_q, rxd_q;
    logic              nack_q;
    slv_flags_t        fl_q;
    logic              addr_hit;

    assign addr_hit = (shr_q[DATA_W-1 -: ADDR_W] == own_addr);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shr_q   <= '0;
            txbuf_q <= '0;
            rxd_q   <= '0;
            nack_q  <= 1'b0;
            fl_q    <= '0;
        end else begin
            if (evt.start) begin
                state_q <= ST_ADDR;
                cnt_q   <= '0;
            end else if (evt.stop) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (evt.rise) begin
                            shr_q <= {shr_q[DATA_W-2:0], evt.sda};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (evt.fall && cnt_q == FULL_CNT) begin
                            if (addr_hit) begin
                                rxd_q    <= shr_q;
                                fl_q.trs <= shr_q[0];
                                if (shr_q[0]) fl_q.tdre <= 1'b1;
                                state_q  <= ST_AACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt.fall) state_q <= fl_q.trs ? ST_TXHOLD : ST_IDLE;
                    end
                    ST_TXHOLD: begin
                        if (!fl_q.tdre) begin
                            shr_q     <= txbuf_q;
                            fl_q.tdre <= 1'b1;
                            cnt_q     <= '0;
                            state_q   <= ST_TXBITS;
                        end else if (!fl_q.trs && rd_rxd) begin
                            fl_q.tdre <= 1'b0;
                            state_q   <= ST_IDLE;
                        end
                    end
                    ST_TXBITS: begin
                        if (evt.fall) begin
                            shr_q <= {shr_q[DATA_W-2:0], 1'b0};
                            if (cnt_q == LAST_BIT) begin
                                cnt_q   <= '0;
                                state_q <= ST_TXACK;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (evt.rise) begin
                            nack_q <= evt.sda;
                        end else if (evt.fall) begin
                            if (nack_q) begin
                                fl_q.tend <= 1'b1;
                                state_q   <= ST_IDLE;
                            end else begin
                                if (fl_q.tdre) fl_q.tend <= 1'b1;
                                state_q <= ST_TXHOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (clr_trs)  fl_q.trs  <= 1'b0;
            if (clr_tend) fl_q.tend <= 1'b0;
            if (wr_txd) begin
                txbuf_q   <= txd;
                fl_q.tdre <= 1'b0;
            end
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        scl_oe = 1'b0;
        case (state_q)
            ST_AACK:   sda_oe = ~ack_sel;
            ST_TXBITS: sda_oe = ~shr_q[DATA_W-1];
            ST_TXHOLD: scl_oe = 1'b1;
            default: ;
        endcase
    end

    assign rxd   = rxd_q;
    assign flags = fl_q;
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
    import i2cs_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SEL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              ack_sel,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              wr_txd,
    input  logic [DATA_W-1:0] txd,
    input  logic              rd_rxd,
    output logic [DATA_W-1:0] rxd,
    input  logic              clr_trs,
    input  logic              clr_tend,
    output logic              trs,
    output logic              tdre,
    output logic              tend,
    input  logic              scl_i,
    output logic              scl_oe,
    input  logic              sda_i,
    output logic              sda_oe
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw, line_filt;
    bus_evt_t           evt;
    slv_flags_t         flags;

    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2cs_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .SEL_W      (SEL_W)
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .thr   (clk_sel),
            .line_i(line_raw[g]),
            .line_o(line_filt[g])
        );
    end

    i2cs_bus_events u_evt (
        .clk  (clk),
        .rst  (rst),
        .scl_f(line_filt[1]),
        .sda_f(line_filt[0]),
        .evt  (evt)
    );

    i2cs_slv_engine #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .ack_sel (ack_sel),
        .own_addr(own_addr),
        .wr_txd  (wr_txd),
        .txd     (txd),
        .rd_rxd  (rd_rxd),
        .clr_trs (clr_trs),
        .clr_tend(clr_tend),
        .evt     (evt),
        .rxd     (rxd),
        .flags   (flags),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );

    assign trs  = flags.trs;
    assign tdre = flags.tdre;
    assign tend = flags.tend;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic wr_txd,
    input logic rd_rxd,
    input logic trs,
    input logic tdre,
    input logic tend,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe
);
    a_r11_off_releases: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_oe && !sda_oe && !trs && !tdre && !tend));

    a_r5_write_empties: assert property (@(posedge clk) disable iff (rst)
        (en && wr_txd) |=> !tdre);

    a_r8_release_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_oe) |-> ($past(!tdre) || $past(rd_rxd && !trs) || $past(!en)));

    a_r7_tend_sda_free: assert property (@(posedge clk) disable iff (rst)
        $rose(tend) |-> !sda_oe);

    a_r3_trs_with_tdre: assert property (@(posedge clk) disable iff (rst)
        ($rose(trs) && !$past(wr_txd)) |-> tdre);

    a_r4_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(sda_oe)) |-> !scl_i);
endmodule

bind i2c_slave_tx i2cs_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .wr_txd(wr_txd),
    .rd_rxd(rd_rxd),
    .trs   (trs),
    .tdre  (tdre),
    .tend  (tend),
    .scl_i (scl_i),
    .scl_oe(scl_oe),
    .sda_oe(sda_oe)
);

// File: tb/sim_i2c_slave_tx.sv
`timescale 1ns/1ps
module sim_i2c_slave_tx;
    localparam int Q = 25;
    localparam logic [6:0] OWN = 7'h3A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic [3:0] clk_sel = 4'd3;
    logic ack_sel = 1'b0;
    logic [6:0] own_addr = OWN;
    logic wr_txd = 1'b0;
    logic [7:0] txd = 8'h00;
    logic rd_rxd = 1'b0;
    logic [7:0] rxd;
    logic clr_trs = 1'b0;
    logic clr_tend = 1'b0;
    logic trs, tdre, tend;
    logic scl_oe, sda_oe;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic scl_bus, sda_bus;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_slave_tx u0 (
        .clk(clk), .rst(rst), .en(en), .clk_sel(clk_sel), .ack_sel(ack_sel),
        .own_addr(own_addr), .wr_txd(wr_txd), .txd(txd), .rd_rxd(rd_rxd),
        .rxd(rxd), .clr_trs(clr_trs), .clr_tend(clr_tend), .trs(trs),
        .tdre(tdre), .tend(tend), .scl_i(scl_bus), .scl_oe(scl_oe),
        .sda_i(sda_bus), .sda_oe(sda_oe)
    );

    function automatic logic exp_ack(input logic en_v, input logic [7:0] frame,
                                     input logic [6:0] own, input logic asel);
        return (en_v && frame[7:1] == own) ? asel : 1'b1;
    endfunction

    function automatic logic [7:0] frame_of(input logic [6:0] a, input logic rw);
        return {a, rw};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wait (scl_bus); wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wait (scl_bus); wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wait (scl_bus); wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wait (scl_bus); wq(Q / 2);
        b = sda_bus; wq(Q - Q / 2);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
    endtask

    task automatic m_rbyte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            v[i] = b;
        end
    endtask

    task automatic h_write(input logic [7:0] v);
        @(negedge clk); txd = v; wr_txd = 1'b1;
        @(negedge clk); wr_txd = 1'b0;
    endtask

    task automatic h_read();
        @(negedge clk); rd_rxd = 1'b1;
        @(negedge clk); rd_rxd = 1'b0;
    endtask

    task automatic h_clr_trs();
        @(negedge clk); clr_trs = 1'b1;
        @(negedge clk); clr_trs = 1'b0;
    endtask

    task automatic h_clr_tend();
        @(negedge clk); clr_tend = 1'b1;
        @(negedge clk); clr_tend = 1'b0;
    endtask

    task automatic wait_tdre();
        while (tdre !== 1'b1) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] rb;
        logic tdre_before;
        logic [7:0] d [4];
        logic pre [4];
        int n;
        logic last_nack;

        void'($urandom(32'd2024));
        wq(5);
        rst = 1'b0;
        wq(5);
        // R11: reset / disabled state
        chk("R11 reset flags", {27'd0, trs, tdre, tend, scl_oe, sda_oe}, 32'd0);
        en = 1'b1;
        wq(5);

        // R1: address mismatch, no ACK
        m_start();
        m_wbyte(frame_of(7'h15, 1'b1));
        m_rbit(a);
        chk("R1 mismatch ack", a, exp_ack(1'b1, frame_of(7'h15, 1'b1), OWN, 1'b0));
        chk("R1 mismatch trs", trs, 1'b0);
        m_stop();

        // R2 / R3: write-direction match
        tdre_before = tdre;
        m_start();
        m_wbyte(frame_of(OWN, 1'b0));
        m_rbit(a);
        chk("R2 ack low", a, 1'b0);
        chk("R3 write dir trs", trs, 1'b0);
        chk("R3 write dir tdre", tdre, tdre_before);
        chk("R3 rxd byte", rxd, frame_of(OWN, 1'b0));
        m_stop();

        // R2: ack_sel = 1 leaves SDA released
        ack_sel = 1'b1;
        m_start();
        m_wbyte(frame_of(OWN, 1'b0));
        m_rbit(a);
        chk("R2 ack_sel high", a, exp_ack(1'b1, frame_of(OWN, 1'b0), OWN, 1'b1));
        ack_sel = 1'b0;
        m_stop();

        // Main read transfer: R3 R4 R5 R6 R7 R8 R10
        m_start();
        m_wbyte(frame_of(OWN, 1'b1));
        m_rbit(a);
        chk("R2 read ack", a, 1'b0);
        chk("R3 read trs", trs, 1'b1);
        chk("R3 read tdre", tdre, 1'b1);
        wq(4 * Q);
        chk("R6 stretch before data", scl_oe, 1'b1);
        h_write(8'hA5);
        chk("R5 write empties", tdre, 1'b0);
        wq(3);
        chk("R5 load refills", tdre, 1'b1);
        chk("R6 release after write", scl_oe, 1'b0);
        h_write(8'h3C);
        chk("R5 queued empties", tdre, 1'b0);
        m_rbyte(rb);
        chk("R4 byte0", rb, 8'hA5);
        m_wbit(1'b0);
        m_rbyte(rb);
        chk("R4 byte1", rb, 8'h3C);
        m_wbit(1'b0);
        chk("R7 tend set", tend, 1'b1);
        chk("R7 scl held", scl_oe, 1'b1);
        h_read();
        wq(2);
        chk("R8 read with trs held", scl_oe, 1'b1);
        h_clr_trs();
        wq(2);
        chk("R8 trs cleared", trs, 1'b0);
        chk("R8 clear alone held", scl_oe, 1'b1);
        h_read();
        wq(2);
        chk("R8 released", scl_oe, 1'b0);
        chk("R8 tdre cleared", tdre, 1'b0);
        h_clr_tend();
        chk("R10 tend cleared", tend, 1'b0);
        m_stop();

        // R9: NACK ends shifting
        m_start();
        m_wbyte(frame_of(OWN, 1'b1));
        m_rbit(a);
        chk("R2 read ack 2", a, 1'b0);
        h_write(8'hC3);
        wq(3);
        m_rbyte(rb);
        chk("R4 byte nack", rb, 8'hC3);
        m_wbit(1'b1);
        chk("R9 tend on nack", tend, 1'b1);
        chk("R9 lines free", {30'd0, scl_oe, sda_oe}, 32'd0);
        m_rbit(a);
        chk("R9 silent after nack", a, 1'b1);
        m_stop();
        h_clr_tend();
        h_clr_trs();

        // R12: short SDA dip while SCL high is not a START
        wq(Q);
        @(negedge clk); sda_m = 1'b0;
        wq(2);
        sda_m = 1'b1;
        wq(Q);
        scl_m = 1'b0;
        wq(Q);
        m_wbyte(frame_of(OWN, 1'b1));
        m_rbit(a);
        chk("R12 glitch ignored", a, 1'b1);
        chk("R12 no transmit mode", trs, 1'b0);
        m_stop();

        // R11: disabled block ignores its address
        en = 1'b0;
        wq(3);
        chk("R11 disabled flags", {29'd0, trs, tdre, tend}, 32'd0);
        m_start();
        m_wbyte(frame_of(OWN, 1'b1));
        m_rbit(a);
        chk("R11 disabled no ack", a, exp_ack(1'b0, frame_of(OWN, 1'b1), OWN, 1'b0));
        m_stop();
        en = 1'b1;
        wq(5);

        // Random read transfers
        for (int t = 0; t < 8; t++) begin
            n = 1 + int'($urandom % 3);
            for (int k = 0; k < 4; k++) begin
                d[k] = 8'($urandom);
                pre[k] = 1'($urandom);
            end
            last_nack = 1'($urandom);
            m_start();
            m_wbyte(frame_of(OWN, 1'b1));
            m_rbit(a);
            chk("R2 random ack", a, 1'b0);
            for (int k = 0; k < n; k++) begin
                if (k == 0 || !pre[k]) begin
                    chk("R6 random stretch", scl_oe, 1'b1);
                    h_write(d[k]);
                end
                wait_tdre();
                if (k + 1 < n && pre[k + 1]) h_write(d[k + 1]);
                m_rbyte(rb);
                chk("R4 random byte", rb, d[k]);
                m_wbit((k == n - 1) ? last_nack : 1'b0);
            end
            if (last_nack) begin
                chk("R9 random nack tend", tend, 1'b1);
                chk("R9 random nack scl", scl_oe, 1'b0);
            end else begin
                chk("R7 random tend", tend, 1'b1);
                chk("R7 random hold", scl_oe, 1'b1);
                h_clr_trs();
                h_read();
                wq(2);
                chk("R8 random release", scl_oe, 1'b0);
            end
            h_clr_tend();
            h_clr_trs();
            m_stop();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule